// File: doc/BRIEF.md
# Serial ADC Power-Mode Interface

This block models the digital side of a single-channel 10-bit serial converter. It oversamples an active-low chip select and a serial clock on a system clock. It counts the serial-clock falling edges in each frame and shifts a 16-bit conversion word out on a data pin that has an output enable. The data word is built from a parallel 10-bit sample that is captured when the frame starts.

How long chip select stays low sets the power mode. The count of falling edges seen when chip select returns high decides the result. With one or none, the mode is left as it was. With two to nine, the conversion is aborted and the block enters shutdown. With ten to fifteen, the word is cut short but the block stays in normal mode. After sixteen, the word is complete.

Any new frame wakes the block. A frame that wakes it from shutdown carries an invalid flag, because the converter would still be powering up during that frame.

Top module: `adc_serial_if`

## Requirements
- R1: While rst_ni is low, and right after it is released, sdata_oe_o=0, sdata_o=0, normal_o=1 and invalid_o=0.
- R2: A falling edge on cs_n_i starts a frame: sdata_oe_o=1 and the edge count restarts from zero.
- R3: The frame word is, from MSB to LSB: four zeros, sample[9:0] MSB first, then two zeros. At the start of the frame sdata_o shows word bit 15. After the k-th serial-clock falling edge (k=1..15) it shows word bit 15-k.
- R4: On the 16th falling edge sdata_oe_o drops to 0. The edge count saturates at 16. While cs_n_i stays low, further falling edges cause no output, and no new frame starts until cs_n_i rises and falls again. sdata_o is 0 whenever sdata_oe_o is 0.
- R5: If cs_n_i rises with fewer than 2 edges counted, normal_o keeps its value and sdata_oe_o goes to 0.
- R6: If cs_n_i rises with 2 to 9 edges counted, normal_o goes to 0 (shutdown) and sdata_oe_o goes to 0.
- R7: If cs_n_i rises with 10 to 15 edges counted, normal_o stays 1 and sdata_oe_o goes to 0, so the word is truncated.
- R8: A cs_n_i falling edge sets normal_o to 1, including when the block is in shutdown.
- R9: invalid_o is set to 1 at the start of a frame that begins in shutdown. It is cleared to 0 at the start of a frame that begins in normal mode.
- R10: A serial-clock falling edge sampled in the same clock cycle as a cs_n_i rising edge is not counted. The mode decision uses the count from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sample_i | input | 10 | Parallel sample value for the next word |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Output enable for sdata_o; 0 means high impedance |
| normal_o | output | 1 | 1 = normal mode, 0 = shutdown |
| invalid_o | output | 1 | Current frame result is unusable (power-up) |

## Verification
Two events can land on the same system-clock cycle: a chip-select rise, which triggers the mode decision, and a serial-clock falling edge, which advances the edge counter. The bench changes both inputs in a single drive. In one case the pending edge would be the tenth, and in another it would be the second. The outcome is judged from normal_o. Shutdown in the first case and an unchanged mode in the second show that the coincident edge was not counted.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  localparam int DATA_W     = 10;
  localparam int WORD_W     = 16;
  localparam int LEAD_W     = 4;
  localparam int GUARD_EDGE = 2;
  localparam int KEEP_EDGE  = 10;

  typedef enum logic {
    MODE_SHUTDOWN = 1'b0,
    MODE_NORMAL   = 1'b1
  } mode_e;
endpackage

// File: rtl/adc_serial_edge.sv
module adc_serial_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sclk_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_fall_o
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall_o   = cs_q & ~cs_n_i;
  assign cs_rise_o   = ~cs_q & cs_n_i;
  assign sclk_fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/adc_serial_cnt.sv
module adc_serial_cnt #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             cs_fall_i,
  input  logic             sclk_fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_o
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(WORD_W);

  logic [CNT_W-1:0] cnt_q;

  // edges only count while selected, never on a frame start, and stop at full
  assign inc_o = sclk_fall_i & ~cs_n_i & ~cs_fall_i & (cnt_q < FULL_C);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cs_fall_i) cnt_q <= '0;
    else if (inc_o)     cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);

  // R2
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> cnt_q == '0);

  // R10
  cnt_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> $stable(cnt_q));
endmodule

// File: rtl/adc_serial_mode.sv
module adc_serial_mode
  import adc_serial_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int GUARD_EDGE = 2,
  parameter int KEEP_EDGE  = 10,
  parameter int CNT_W      = $clog2(WORD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             normal_o,
  output logic             invalid_o
);
  localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_EDGE);
  localparam logic [CNT_W-1:0] KEEP_C  = CNT_W'(KEEP_EDGE);

  mode_e mode_q;
  logic  invalid_q;
  logic  shut_win;

  assign shut_win = (cnt_i >= GUARD_C) && (cnt_i < KEEP_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_NORMAL;
      invalid_q <= 1'b0;
    end else if (cs_fall_i) begin
      mode_q    <= MODE_NORMAL;
      invalid_q <= (mode_q == MODE_SHUTDOWN);
    end else if (cs_rise_i && shut_win) begin
      mode_q    <= MODE_SHUTDOWN;
    end
  end

  assign normal_o  = (mode_q == MODE_NORMAL);
  assign invalid_o = invalid_q;

  // R8
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> mode_q == MODE_NORMAL);

  // R5
  glitch_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && cnt_i < GUARD_C) |=> $stable(mode_q));

  // R6
  shut_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && cnt_i >= GUARD_C && cnt_i < KEEP_C) |=> mode_q == MODE_SHUTDOWN);

  // R7
  trunc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && cnt_i >= KEEP_C) |=> mode_q == MODE_NORMAL);

  // R9
  invalid_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall_i && mode_q == MODE_SHUTDOWN) |=> invalid_q);
endmodule

// File: rtl/adc_serial_shift.sv
module adc_serial_shift #(
  parameter int DATA_W = 10,
  parameter int WORD_W = 16,
  parameter int LEAD_W = 4,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              inc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdata_o,
  output logic              oe_o
);
  localparam int TRAIL_W = WORD_W - LEAD_W - DATA_W;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] word, sr_q;
  logic              active_q;
  logic              last_edge;

  generate
    if (TRAIL_W > 0) begin : g_trail
      assign word = {{LEAD_W{1'b0}}, sample_i, {TRAIL_W{1'b0}}};
    end else begin : g_no_trail
      assign word = {{LEAD_W{1'b0}}, sample_i};
    end
  endgenerate

  assign last_edge = inc_i && (cnt_i == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      active_q <= 1'b0;
    end else if (cs_fall_i) begin
      sr_q     <= word;
      active_q <= 1'b1;
    end else if (cs_rise_i) begin
      active_q <= 1'b0;
    end else if (inc_i) begin
      sr_q <= {sr_q[WORD_W-2:0], 1'b0};
      if (last_edge) active_q <= 1'b0;
    end
  end

  assign oe_o    = active_q;
  assign sdata_o = active_q & sr_q[WORD_W-1];

  // R2
  start_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> active_q);
endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_serial_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int WW    = WORD_W,
  parameter int LW    = LEAD_W,
  parameter int GUARD = GUARD_EDGE,
  parameter int KEEP  = KEEP_EDGE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_i,
  input  logic          sclk_i,
  input  logic [DW-1:0] sample_i,
  output logic          sdata_o,
  output logic          sdata_oe_o,
  output logic          normal_o,
  output logic          invalid_o
);
  localparam int CW = $clog2(WW + 1);

  logic          cs_fall, cs_rise, sclk_fall, inc;
  logic [CW-1:0] cnt;

  adc_serial_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_i),
    .sclk_i     (sclk_i),
    .cs_fall_o  (cs_fall),
    .cs_rise_o  (cs_rise),
    .sclk_fall_o(sclk_fall)
  );

  adc_serial_cnt #(.WORD_W(WW), .CNT_W(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_i),
    .cs_fall_i  (cs_fall),
    .sclk_fall_i(sclk_fall),
    .cnt_o      (cnt),
    .inc_o      (inc)
  );

  adc_serial_mode #(.WORD_W(WW), .GUARD_EDGE(GUARD), .KEEP_EDGE(KEEP), .CNT_W(CW)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_fall_i(cs_fall),
    .cs_rise_i(cs_rise),
    .cnt_i    (cnt),
    .normal_o (normal_o),
    .invalid_o(invalid_o)
  );

  adc_serial_shift #(.DATA_W(DW), .WORD_W(WW), .LEAD_W(LW), .CNT_W(CW)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_fall_i(cs_fall),
    .cs_rise_i(cs_rise),
    .inc_i    (inc),
    .cnt_i    (cnt),
    .sample_i (sample_i),
    .sdata_o  (sdata_o),
    .oe_o     (sdata_oe_o)
  );

  // R4
  word_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == CW'(WW) |-> !sdata_oe_o);

  // R5
  deselect_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !sdata_oe_o);

  // R4
  quiet_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);
endmodule

// File: tb/tb_adc_serial_if.sv
`timescale 1ns/1ps
module tb_adc_serial_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b1;
  logic [9:0] sample = '0;
  logic       sdata, oe, normal, invalid;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  model_normal = 1'b1;
  logic [15:0] word;

  always #2.5 clk = ~clk;

  adc_serial_if dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_n_i    (cs_n),
    .sclk_i    (sclk),
    .sample_i  (sample),
    .sdata_o   (sdata),
    .sdata_oe_o(oe),
    .normal_o  (normal),
    .invalid_o (invalid)
  );

  typedef struct packed {
    logic [9:0] smp;
    logic [4:0] edges;
    logic       exp_norm;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{10'h2A5, 5'd16, 1'b1},
    '{10'h3FF, 5'd1,  1'b1},
    '{10'h155, 5'd5,  1'b0},
    '{10'h0F0, 5'd16, 1'b1},
    '{10'h201, 5'd12, 1'b1},
    '{10'h0AA, 5'd2,  1'b0},
    '{10'h333, 5'd0,  1'b1},
    '{10'h1C7, 5'd9,  1'b0},
    '{10'h3A5, 5'd10, 1'b1},
    '{10'h001, 5'd16, 1'b1},
    '{10'h200, 5'd20, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_down();
    sclk = 1'b0;
    wait_clk(2);
  endtask

  task automatic sclk_up();
    sclk = 1'b1;
    wait_clk(2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_clk(3);
    chk("R1 oe in reset", oe, 0);
    chk("R1 sdata in reset", sdata, 0);
    chk("R1 normal in reset", normal, 1);
    chk("R1 invalid in reset", invalid, 0);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 oe after reset", oe, 0);

    // table of frames
    for (int i = 0; i < 11; i++) begin
      logic exp_inv;
      word    = {4'b0, VECS[i].smp, 2'b0};
      exp_inv = !model_normal;
      sample  = VECS[i].smp;
      cs_n    = 1'b0;
      wait_clk(2);
      chk("R2 oe at frame start", oe, 1);
      chk("R8 normal at frame start", normal, 1);
      chk("R9 invalid flag", invalid, exp_inv);
      chk("R3 first bit", sdata, word[15]);
      for (int k = 1; k <= int'(VECS[i].edges); k++) begin
        sclk_down();
        if (k < 16) chk("R3 data bit", sdata, word[15-k]);
        else        chk("R4 oe after word", oe, 0);
        sclk_up();
      end
      cs_n = 1'b1;
      wait_clk(2);
      chk("R5/R6/R7 oe after deselect", oe, 0);
      if (VECS[i].edges < 2)       chk("R5 mode kept", normal, VECS[i].exp_norm);
      else if (VECS[i].edges < 10) chk("R6 shutdown", normal, VECS[i].exp_norm);
      else if (VECS[i].edges < 16) chk("R7 truncate keeps normal", normal, VECS[i].exp_norm);
      else                         chk("R4 full word keeps normal", normal, VECS[i].exp_norm);
      model_normal = VECS[i].exp_norm;
      wait_clk(2);
    end

    // R4 chip select idles low after a full word
    cs_n = 1'b0;
    wait_clk(2);
    for (int k = 1; k <= 16; k++) begin sclk_down(); sclk_up(); end
    for (int k = 0; k < 3; k++) begin
      sclk_down();
      chk("R4 no output while idle low", oe, 0);
      chk("R4 sdata quiet", sdata, 0);
      sclk_up();
    end
    chk("R4 normal after idle low", normal, 1);
    cs_n = 1'b1;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(2);
    chk("R4 new frame after rise and fall", oe, 1);
    cs_n = 1'b1;
    wait_clk(2);

    // R10 coincident chip-select rise and tenth edge
    cs_n = 1'b0;
    wait_clk(2);
    for (int k = 1; k <= 9; k++) begin sclk_down(); sclk_up(); end
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(2);
    chk("R10 coincident tenth edge ignored", normal, 0);
    sclk = 1'b1;
    wait_clk(2);

    // R10 coincident rise and second edge on a wake frame
    cs_n = 1'b0;
    wait_clk(2);
    chk("R9 wake frame invalid", invalid, 1);
    sclk_down();
    sclk_up();
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(2);
    chk("R10 coincident second edge ignored", normal, 1);
    sclk = 1'b1;
    wait_clk(2);

    // R1 reset mid-frame
    cs_n = 1'b0;
    wait_clk(2);
    for (int k = 1; k <= 5; k++) begin sclk_down(); sclk_up(); end
    rst_n = 1'b0;
    wait_clk(2);
    chk("R1 oe after mid-frame reset", oe, 0);
    chk("R1 normal after mid-frame reset", normal, 1);
    chk("R1 invalid after mid-frame reset", invalid, 0);
    cs_n = 1'b1;
    rst_n = 1'b1;
    wait_clk(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule